// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block recovers a card's answer to a reader frame when the answer carries no start marker, no stop marker and no length field. The reader already knows how many bits to expect. It pulses `start` at the moment its own frame ends and supplies the expected count. The block then waits a fixed number of timing ticks. After that it cuts time into back-to-back windows of equal length, one window per bit. The receive input is a digitised, hysteresis-filtered copy of the antenna signal. A load-modulated subcarrier makes it toggle many times per window, and an unmodulated carrier leaves it still.

Every level change inside a window is counted, including both rising and falling changes. A window whose count falls inside an acceptance band becomes a 1 bit, and any other count becomes a 0 bit. Bits are collected least significant first. After the last window the block raises `done` for one cycle, reports how many bits it took, and returns to idle. In idle its tick counter stays cleared, so the next reader frame sets a fresh time reference. A silent channel therefore reads as all zeros.

The controller has three states. `ST_IDLE` waits for `start`. `ST_GAP` counts the response delay. `ST_WIN` counts edges in the current bit window. The transitions are as follows:
- `start` moves any state to `ST_GAP`, or to `ST_IDLE` with an immediate `done` when zero bits are requested.
- The delay expiring moves `ST_GAP` to `ST_WIN`.
- Each window closing keeps the block in `ST_WIN`, except that the last window closing moves it to `ST_IDLE`.

Top module: `sc_edge_rx`

## Requirements
- R1: After reset, `data_out` is 0, `bits_out` is 0 and `done` is 0.
- R2: The first bit window opens on the 490th `tick` after `start`. Input edges before that tick do not affect any bit.
- R3: Each window closes on its 150th `tick`, and the next window opens in that same cycle. An input change sampled one clock before a closing tick is counted in the following window.
- R4: Both rising and falling changes of `rx_level` each add one to the current window's edge count, after a two-flop synchroniser.
- R5: A window decodes as 1 exactly when its edge count is greater than 20 and less than 60. For example, counts of 20 and 60 decode as 0, and counts of 21, 42 and 59 decode as 1.
- R6: Bit i of the response is placed in `data_out[i]`, and bits at or above the requested count read 0.
- R7: A requested count above 16 is treated as 16, and `bits_out` then reports 16.
- R8: A response window with no input edges decodes as 0, so a silent channel gives `data_out` = 0.
- R9: `done` is high for exactly one cycle, beginning one cycle after the tick that closes the last window. At that point `bits_out` equals the accepted bit count. `data_out` and `bits_out` then hold until the next `start`.
- R10: The per-window edge count saturates at 63, so 85 edges in a window decode as 0.
- R11: An input change sampled two clocks before a window's closing tick is counted in the window that is closing.
- R12: `start` during a reception abandons it. It clears `data_out` and `bits_out` in the next cycle and begins timing again from the new `start`.
- R13: `start` with a requested count of 0 gives `done` in the next cycle, with `bits_out` = 0 and `data_out` = 0.
- R14: In idle, `tick` and `rx_level` activity produce no `done` and change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | 1 | Digitised receive level, asynchronous |
| tick | input | 1 | Timing strobe, one cycle per tick |
| start | input | 1 | Pulse marking the end of the reader frame |
| req_bits | input | 5 | Requested number of response bits |
| data_out | output | 16 | Decoded bits, LSB first |
| bits_out | output | 5 | Number of bits delivered |
| done | output | 1 | One-cycle completion pulse |

## Verification
An edge and a window boundary can fall in the same cycle. The edge-count increment and the window-closing tick then act together: the count is used for the bit decision and cleared for the next window at once. The bench provokes this by placing a synchronised input change exactly on the closing tick, which must push a window from 20 edges to 21 and decode a 1. It also places a change one cycle later, after the closing tick, where the edge must instead be credited to the next window. Both cases are judged only from the decoded `data_out` bits.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_WIN  = 2'd2
    } rx_state_e;
endpackage

// File: rtl/sc_rx_sync.sv
// Multi-flop synchroniser with a change detector on the settled level.
module sc_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic chg_o
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], din};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign chg_o = sh_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/sc_rx_timer.sv
// Tick counter that reports the tick completing a phase of limit_i ticks.
module sc_rx_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         tick_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);
    logic [W-1:0] cnt_q;

    assign hit_o = tick_i && (cnt_q == limit_i - W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i || hit_o)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/sc_rx_edgecnt.sv
// Saturating per-window edge counter; total_o includes this cycle's edge.
module sc_rx_edgecnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] total_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    assign total_o = (inc_i && (cnt_q != TOP)) ? cnt_q + W'(1) : cnt_q;
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else
            cnt_q <= total_o;
    end
endmodule

// File: rtl/sc_edge_rx.sv
module sc_edge_rx
    import sc_rx_pkg::*;
#(
    parameter int GAP_TICKS   = 490,
    parameter int WIN_TICKS   = 150,
    parameter int BAND_LO     = 20,
    parameter int BAND_HI     = 60,
    parameter int MAX_BITS    = 16,
    parameter int REQ_W       = 5,
    parameter int EDGE_W      = 6,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_level,
    input  logic                tick,
    input  logic                start,
    input  logic [REQ_W-1:0]    req_bits,
    output logic [MAX_BITS-1:0] data_out,
    output logic [CNT_W-1:0]    bits_out,
    output logic                done
);
    localparam int TMR_MAX = (GAP_TICKS > WIN_TICKS) ? GAP_TICKS : WIN_TICKS;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int IDX_W   = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

    rx_state_e          state_q, state_d;
    logic [IDX_W-1:0]   bit_idx_q;
    logic [CNT_W-1:0]   nbits_q;
    logic [CNT_W-1:0]   req_eff;
    logic [TMR_W-1:0]   limit;
    logic               tmr_clr, phase_hit;
    logic               edge_pulse;
    logic               einc, eclr;
    logic [EDGE_W-1:0]  ecnt, etotal;
    logic               win_close, last_win, bit_val;
    logic [MAX_BITS-1:0] data_q;
    logic [CNT_W-1:0]   bits_q;
    logic               done_q;

    // Requested count limited to the widest response.
    always_comb begin
        if (int'(req_bits) > MAX_BITS)
            req_eff = CNT_W'(MAX_BITS);
        else
            req_eff = CNT_W'(req_bits);
    end

    sc_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_level),
        .chg_o (edge_pulse)
    );

    assign limit   = (state_q == ST_GAP) ? TMR_W'(GAP_TICKS) : TMR_W'(WIN_TICKS);
    assign tmr_clr = start || (state_q == ST_IDLE);

    sc_rx_timer #(.W(TMR_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tmr_clr),
        .tick_i  (tick),
        .limit_i (limit),
        .hit_o   (phase_hit)
    );

    assign win_close = (state_q == ST_WIN) && phase_hit && !start;
    assign einc      = edge_pulse && (state_q == ST_WIN);
    assign eclr      = start || (state_q != ST_WIN) || phase_hit;

    sc_rx_edgecnt #(.W(EDGE_W)) ecnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (eclr),
        .inc_i   (einc),
        .cnt_o   (ecnt),
        .total_o (etotal)
    );

    assign bit_val  = (int'(etotal) > BAND_LO) && (int'(etotal) < BAND_HI);
    assign last_win = (CNT_W'(bit_idx_q) + CNT_W'(1)) == nbits_q;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = (req_eff == '0) ? ST_IDLE : ST_GAP;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_GAP:  if (phase_hit) state_d = ST_WIN;
                ST_WIN:  if (phase_hit && last_win) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register and bit bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_idx_q <= '0;
            nbits_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                bit_idx_q <= '0;
                nbits_q   <= req_eff;
            end else if (win_close) begin
                bit_idx_q <= bit_idx_q + IDX_W'(1);
            end
        end
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            bits_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                data_q <= '0;
                bits_q <= '0;
                done_q <= (req_eff == '0);
            end else if (win_close) begin
                data_q[bit_idx_q] <= bit_val;
                if (last_win) begin
                    bits_q <= nbits_q;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign data_out = data_q;
    assign bits_out = bits_q;
    assign done     = done_q;
endmodule

// File: rtl/sc_edge_rx_chk.sv
module sc_edge_rx_chk
    import sc_rx_pkg::*;
#(
    parameter int MAX_BITS = 16,
    parameter int EDGE_W   = 6,
    localparam int CNT_W   = $clog2(MAX_BITS + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                done,
    input logic [MAX_BITS-1:0] data_out,
    input logic [CNT_W-1:0]    bits_out,
    input rx_state_e           state_q,
    input logic [EDGE_W-1:0]   ecnt,
    input logic                einc,
    input logic                eclr
);
    localparam logic [EDGE_W-1:0] ETOP = {EDGE_W{1'b1}};

    p_gap_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> (data_out == '0));

    p_bits_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bits_out) <= MAX_BITS);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ecnt == ETOP && einc && !eclr) |=> (ecnt == ETOP));

    p_start_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (data_out == '0 && bits_out == '0));

    p_idle_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> ($stable(data_out) && $stable(bits_out) && !done));
endmodule

bind sc_edge_rx sc_edge_rx_chk #(.MAX_BITS(MAX_BITS), .EDGE_W(EDGE_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .data_out (data_out),
    .bits_out (bits_out),
    .state_q  (state_q),
    .ecnt     (ecnt),
    .einc     (einc),
    .eclr     (eclr)
);

// File: tb/sc_edge_rx_tb_top.sv
`timescale 1ns/1ps
module sc_edge_rx_tb_top;
    localparam int GAP = 490;
    localparam int WIN = 150;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_level = 1'b0;
    logic        tick = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  req_bits = '0;
    logic [15:0] data_out;
    logic [4:0]  bits_out;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    sc_edge_rx dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_level (rx_level),
        .tick     (tick),
        .start    (start),
        .req_bits (req_bits),
        .data_out (data_out),
        .bits_out (bits_out),
        .done     (done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic toggles(input int n);
        for (int i = 0; i < n; i++) begin
            rx_level = ~rx_level;
            @(negedge clk);
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic win(input int n);
        toggles(n);
        ticks(WIN);
    endtask

    task automatic start_rx(input int n);
        req_bits = 5'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic expect_done(input string req, input logic [15:0] d, input int nb);
        check({req, " done"}, 32'(done), 32'd1);
        check({req, " data"}, 32'(data_out), 32'(d));
        check({req, " bits"}, 32'(bits_out), 32'(nb));
        @(negedge clk);
        check({req, " done pulse R9"}, 32'(done), 32'd0);
        check({req, " hold R9"}, 32'(data_out), 32'(d));
    endtask

    // R6 R9 R4: frame from a pattern, 1 -> 42 edges, 0 -> 3 edges
    task automatic run_frame(input string req, input int n, input logic [15:0] pat);
        int eff;
        logic [15:0] exp;
        eff = (n > 16) ? 16 : n;
        exp = '0;
        start_rx(n);
        ticks(GAP);
        for (int i = 0; i < eff; i++) begin
            win(pat[i] ? 42 : 3);
            exp[i] = pat[i];
        end
        expect_done(req, exp, eff);
    endtask

    task automatic t_reset;
        check("R1 data", 32'(data_out), 32'd0);
        check("R1 bits", 32'(bits_out), 32'd0);
        check("R1 done", 32'(done), 32'd0);
    endtask

    task automatic t_basic;
        run_frame("R6 R4 basic", 8, 16'h00A5);
    endtask

    task automatic t_band;
        start_rx(6);
        ticks(GAP);
        win(20); win(21); win(59); win(60); win(42); win(0);
        expect_done("R5 band", 16'h0016, 6);
    endtask

    task automatic t_sat;
        start_rx(2);
        ticks(GAP);
        win(85); win(30);
        expect_done("R10 saturate", 16'h0002, 2);
    endtask

    task automatic t_clamp;
        run_frame("R7 clamp", 20, 16'hC3A5);
    endtask

    task automatic t_silent;
        start_rx(16);
        ticks(GAP);
        for (int i = 0; i < 16; i++) win(0);
        expect_done("R8 silent", 16'h0000, 16);
    endtask

    // R2 R3: window opening and closing tick positions
    task automatic t_timing;
        start_rx(2);
        toggles(50);
        ticks(GAP - 1);
        toggles(30);
        ticks(1);
        ticks(WIN - 1);
        toggles(30);
        ticks(1);
        win(0);
        expect_done("R2 R3 timing", 16'h0001, 2);
    endtask

    // R11 R3: edge on the closing tick vs one cycle after it
    task automatic t_boundary;
        start_rx(3);
        ticks(GAP);
        toggles(20);
        ticks(WIN - 1);
        rx_level = ~rx_level;
        @(negedge clk);
        @(negedge clk);
        ticks(1);
        toggles(20);
        ticks(WIN - 1);
        rx_level = ~rx_level;
        @(negedge clk);
        ticks(1);
        win(20);
        expect_done("R11 boundary", 16'h0005, 3);
    endtask

    task automatic t_restart;
        start_rx(4);
        ticks(GAP);
        win(42);
        check("R12 partial no done", 32'(done), 32'd0);
        start_rx(2);
        check("R12 cleared data", 32'(data_out), 32'd0);
        check("R12 cleared bits", 32'(bits_out), 32'd0);
        ticks(GAP);
        win(0);
        win(42);
        expect_done("R12 restart", 16'h0002, 2);
    endtask

    task automatic t_zero;
        start_rx(0);
        check("R13 done", 32'(done), 32'd1);
        check("R13 bits", 32'(bits_out), 32'd0);
        check("R13 data", 32'(data_out), 32'd0);
        @(negedge clk);
        check("R13 single pulse", 32'(done), 32'd0);
    endtask

    task automatic t_idle;
        int seen;
        run_frame("R14 setup", 4, 16'h0009);
        seen = 0;
        fork
            begin
                toggles(40);
                ticks(2 * WIN + GAP);
            end
            begin
                repeat (700) begin
                    @(negedge clk);
                    if (done) seen++;
                end
            end
        join
        check("R14 no done", 32'(seen), 32'd0);
        check("R14 data hold", 32'(data_out), 32'h9);
        check("R14 bits hold", 32'(bits_out), 32'd4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_band();
        t_sat();
        t_clamp();
        t_silent();
        t_timing();
        t_boundary();
        t_restart();
        t_zero();
        t_idle();
        report();
        $finish;
    end
endmodule